// File: doc/BRIEF.md
# Modulo-255 Dual-Sum Packet Checksum Unit

This block computes and verifies a two-byte checksum over a byte packet. It keeps two running sums in ones'-complement (modulo 2^W−1) arithmetic. The first sum adds up the bytes. The second adds up the successive values of the first, so the second sum depends on where each byte sits in the packet.

In generate mode, data bytes pass straight from the input to the output. After the packet's last byte the unit appends two check bytes. These are chosen so that running the same two sums over the whole extended packet drives both sums to zero. In check mode the unit consumes a complete packet, check bytes included. One cycle after the final byte it raises a single-cycle done pulse together with an error flag.

The input stream carries valid, first and last flags. The output uses a plain valid/ready handshake.

Top module: `dual_sum_cksum`

## Requirements
- R1: All sums are modulo 2^W−1 with W = 8 by default. A raw total of 255 reads as 0, a raw total of 256 reads as 1, and an input byte of 255 acts as 0.
- R2: Both sums are zero after reset and after each packet ends. A check-mode packet ends when its last byte is accepted. A generate-mode packet ends when its second check byte is accepted.
- R3: For each accepted byte d, the first sum becomes A+d. The second sum then becomes B plus that new first sum.
- R4: In generate mode (`mode_i` = 0) each data byte appears on `out_data_o` in the same cycle with `out_last_o` = 0. `in_ready_o` equals `out_ready_i` while data is flowing.
- R5: After the last data byte of a generate packet, the unit outputs X = −(A+B) and then Y = B, with `out_last_o` = 1 on Y only. For data 6, 15, 20, 1 the check bytes are 103 and 110.
- R6: While a check byte is waiting with `out_ready_i` low, it holds its value and valid, and `in_ready_o` stays low.
- R7: In check mode (`mode_i` = 1), `in_ready_o` is high and `out_valid_o` is low. One cycle after the last byte is accepted, `done_o` pulses for one cycle. `err_o` is 0 only if both final sums are zero.
- R8: The packet 6, 15, 20, 2, 103, 110 checked in check mode gives `err_o` = 1.
- R9: A byte accepted with `in_first_i` = 1 restarts both sums from zero before that byte is added, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = generate, 1 = check; changed only between packets |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | W | Input byte |
| in_first_i | input | 1 | Byte starts a packet (restarts sums) |
| in_last_i | input | 1 | Byte ends a packet |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | W | Passed-through data or check byte |
| out_last_o | output | 1 | Final check byte of a generated packet |
| out_ready_i | input | 1 | Downstream can take the output byte |
| done_o | output | 1 | One-cycle pulse after a checked packet |
| err_o | output | 1 | Check result, valid with done_o |

## Verification
A wrong sum state is not visible while bytes are flowing. It first shows at the end of a packet: as wrong check bytes on the two cycles after the last data byte, or as a wrong error flag one cycle after the last checked byte. Sums that are not cleared, or not restarted on a first flag, only show up in the next packet's check bytes or verdict. For that reason the bench runs packets back to back, includes packets that restart in the middle, and includes packets with saturating bytes, and compares every check byte and verdict. Stalls on the output ready expose check bytes that change or get lost while they wait.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  typedef enum logic [1:0] {
    ST_DATA   = 2'd0,
    ST_EMIT_X = 2'd1,
    ST_EMIT_Y = 2'd2
  } cks_state_e;

  localparam logic MODE_GEN = 1'b0;
  localparam logic MODE_CHK = 1'b1;
endpackage

// File: rtl/mod_add.sv
// Ones'-complement adder: end-around carry, all-ones folded to zero.
module mod_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0]   raw;
  logic [W-1:0] wrap;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    wrap  = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    sum_o = (&wrap) ? '0 : wrap;
  end
endmodule

// File: rtl/cksum_acc.sv
module cksum_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         restart_i,
  input  logic         clear_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] a_nxt_o,
  output logic [W-1:0] b_nxt_o
);
  logic [W-1:0] a_q, b_q, a_base, b_base;

  assign a_base = restart_i ? '0 : a_q;
  assign b_base = restart_i ? '0 : b_q;

  mod_add #(.W(W)) i_add_a (.a_i(a_base), .b_i(data_i),  .sum_o(a_nxt_o));
  mod_add #(.W(W)) i_add_b (.a_i(b_base), .b_i(a_nxt_o), .sum_o(b_nxt_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (clear_i) begin
      a_q <= '0;
      b_q <= '0;
    end else if (step_i) begin
      a_q <= a_nxt_o;
      b_q <= b_nxt_o;
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;

  // R1: stored sums are always in normalized form
  assert_sum_normalized_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&a_q) && !(&b_q));
endmodule

// File: rtl/cksum_bytes.sv
// Check bytes that zero both sums: X = -(A+B), Y = B.
module cksum_bytes #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic [W-1:0] ab_sum;

  mod_add #(.W(W)) i_add_ab (.a_i(a_i), .b_i(b_i), .sum_o(ab_sum));

  assign x_o = (ab_sum == '0) ? '0 : ~ab_sum;
  assign y_o = b_i;
endmodule

// File: rtl/dual_sum_cksum.sv
module dual_sum_cksum
  import cksum_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  input  logic         in_first_i,
  input  logic         in_last_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         out_last_o,
  input  logic         out_ready_i,
  output logic         done_o,
  output logic         err_o
);
  cks_state_e   st_q, st_d;
  logic         accept, chk_end, gen_end, y_taken, clear;
  logic [W-1:0] a_q, b_q, a_nxt, b_nxt, x_byte, y_byte;
  logic         done_q, err_q;

  assign in_ready_o = (st_q == ST_DATA) && ((mode_i == MODE_CHK) || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;
  assign chk_end    = accept && in_last_i && (mode_i == MODE_CHK);
  assign gen_end    = accept && in_last_i && (mode_i == MODE_GEN);
  assign y_taken    = (st_q == ST_EMIT_Y) && out_ready_i;
  assign clear      = chk_end || y_taken;

  cksum_acc #(.W(W)) i_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (accept),
    .restart_i(in_first_i),
    .clear_i  (clear),
    .data_i   (in_data_i),
    .a_o      (a_q),
    .b_o      (b_q),
    .a_nxt_o  (a_nxt),
    .b_nxt_o  (b_nxt)
  );

  cksum_bytes #(.W(W)) i_bytes (
    .a_i(a_q),
    .b_i(b_q),
    .x_o(x_byte),
    .y_o(y_byte)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DATA:   if (gen_end)     st_d = ST_EMIT_X;
      ST_EMIT_X: if (out_ready_i) st_d = ST_EMIT_Y;
      ST_EMIT_Y: if (out_ready_i) st_d = ST_DATA;
      default:                    st_d = ST_DATA;
    endcase
  end

  always_comb begin
    out_valid_o = 1'b1;
    out_data_o  = x_byte;
    out_last_o  = 1'b0;
    unique case (st_q)
      ST_DATA: begin
        out_valid_o = in_valid_i && (mode_i == MODE_GEN);
        out_data_o  = in_data_i;
      end
      ST_EMIT_Y: begin
        out_data_o = y_byte;
        out_last_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_DATA;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= chk_end;
      if (chk_end) err_q <= (a_nxt != '0) || (b_nxt != '0);
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R2: a checked packet leaves both sums at zero
  assert_clear_after_check_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_end |=> (a_q == '0) && (b_q == '0));

  // R5: Y with last follows an accepted X
  assert_y_after_x_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EMIT_X && out_ready_i) |=> out_valid_o && out_last_o);

  // R6: stalled check byte holds
  assert_hold_check_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_DATA && !out_ready_i) |=> out_valid_o && $stable(out_data_o) && !in_ready_o);

  // R7: no output traffic in check mode
  assert_chk_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && mode_i == MODE_CHK) |-> !out_valid_o && in_ready_o);

  // R9: a first byte restarts the first sum
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_first_i && !(&in_data_i) && !chk_end) |=> a_q == $past(in_data_i));
endmodule

// File: tb/test_dual_sum_cksum.sv
module test_dual_sum_cksum;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_first = 1'b0;
  logic         in_last = 1'b0;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_last;
  logic         out_ready = 1'b1;
  logic         done, err;

  int n_checks = 0;
  int n_fail = 0;
  bit ready_rand = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  int    exp_out_q[$];
  string tag_out_q[$];
  int    exp_err_q[$];
  string tag_err_q[$];
  int    pkt[32];

  always #2.5 clk = ~clk;

  dual_sum_cksum #(.W(W)) i_dual_sum_cksum (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_first_i(in_first), .in_last_i(in_last),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready), .done_o(done), .err_o(err)
  );

  // output backpressure pattern
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= ready_rand ? lfsr[0] : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare at transfer time
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_out_q.size() == 0)
          check(1'b0, "R7 unexpected output", int'({out_last, out_data}), -1);
        else begin
          int    e;
          string t;
          e = exp_out_q.pop_front();
          t = tag_out_q.pop_front();
          check(int'({out_last, out_data}) == e, t, int'({out_last, out_data}), e);
        end
      end
      if (done) begin
        if (exp_err_q.size() == 0)
          check(1'b0, "R7 unexpected done", int'(err), -1);
        else begin
          int    e;
          string t;
          e = exp_err_q.pop_front();
          t = tag_err_q.pop_front();
          check(int'(err) == e, t, int'(err), e);
        end
      end
    end
  end

  function automatic int madd(input int a, input int b);
    return (a + b) % 255;
  endfunction

  // model + driver; restart_at < 0 means no mid-packet first flag
  task automatic send_pkt(input bit chk, input int n, input int restart_at, input string tag);
    int a = 0;
    int b = 0;
    for (int i = 0; i < n; i++) begin
      if (i == 0 || i == restart_at) begin a = 0; b = 0; end
      a = madd(a, pkt[i]);
      b = madd(b, a);
      if (!chk) begin
        exp_out_q.push_back(pkt[i]);
        tag_out_q.push_back({tag, " R4 passthrough"});
      end
    end
    if (!chk) begin
      exp_out_q.push_back((255 - madd(a, b)) % 255);
      tag_out_q.push_back({tag, " R5/R6 byte X"});
      exp_out_q.push_back(256 + b);
      tag_out_q.push_back({tag, " R5/R6 byte Y"});
    end else begin
      exp_err_q.push_back((a != 0 || b != 0) ? 1 : 0);
      tag_err_q.push_back({tag, " R7 verdict"});
    end
    mode = chk;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = pkt[i][W-1:0];
      in_first = (i == 0 || i == restart_at);
      in_last  = (i == n - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  // append check bytes computed by the bench
  task automatic seal(input int n);
    int a = 0;
    int b = 0;
    for (int i = 0; i < n; i++) begin
      a = madd(a, pkt[i]);
      b = madd(b, a);
    end
    pkt[n]     = (255 - madd(a, b)) % 255;
    pkt[n + 1] = b;
  endtask

  task automatic drain();
    while (exp_out_q.size() != 0 || exp_err_q.size() != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2 reset out_valid", int'(out_valid), 0);
    check(done == 1'b0, "R2 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5: known vector 6,15,20,1 -> 103,110
    pkt[0] = 6; pkt[1] = 15; pkt[2] = 20; pkt[3] = 1;
    check(((255 - madd(42, 110)) % 255) == 103, "R5 model X", (255 - madd(42, 110)) % 255, 103);
    send_pkt(1'b0, 4, -1, "gen_known");
    drain();

    // R7: good packet passes
    pkt[4] = 103; pkt[5] = 110;
    send_pkt(1'b1, 6, -1, "chk_good");
    drain();

    // R8: damaged byte detected
    pkt[3] = 2;
    send_pkt(1'b1, 6, -1, "chk_damaged_R8");
    drain();

    // R1: saturating bytes, with backpressure
    ready_rand = 1'b1;
    for (int i = 0; i < 7; i++) pkt[i] = (i % 2 == 0) ? 255 : 254;
    send_pkt(1'b0, 7, -1, "gen_wrap_R1");
    seal(7);
    send_pkt(1'b1, 9, -1, "chk_wrap_R1");

    // R9: mid-packet restart, both modes
    for (int i = 0; i < 10; i++) pkt[i] = 17 * i + 3;
    send_pkt(1'b0, 10, 4, "gen_restart_R9");
    drain();
    for (int i = 0; i < 6; i++) pkt[i] = 9 + i;
    for (int i = 6; i < 9; i++) pkt[i] = 40 * i;
    seal(9);
    for (int i = 0; i < 11; i++) pkt[i + 3] = pkt[i];
    pkt[0] = 200; pkt[1] = 13; pkt[2] = 77;
    send_pkt(1'b1, 14, 3, "chk_restart_R9");

    // R2/R3: back-to-back single-byte checks and a long generated packet
    pkt[0] = 0;
    send_pkt(1'b1, 1, -1, "chk_zero_R2");
    pkt[0] = 5;
    send_pkt(1'b1, 1, -1, "chk_one_R3");
    for (int i = 0; i < 20; i++) pkt[i] = (i * 37 + 11) % 256;
    send_pkt(1'b0, 20, -1, "gen_long_R3");
    seal(20);
    send_pkt(1'b1, 22, -1, "chk_long_R3");
    pkt[21] = (pkt[21] + 1) % 255;
    send_pkt(1'b1, 22, -1, "chk_badY_R8");
    drain();
    repeat (4) @(posedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule